// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a small 32-bit processor that completes one instruction in every clock cycle. It fetches a word from an external instruction port at the address held in its program counter. It decodes the word and reads two operands from a 32-entry register file. It then computes in an ALU and, on the same clock edge, writes back the result and moves the program counter on. Loads and stores go through a separate data port that has an address, write data, a write strobe and read data. Both memories sit outside the core and are read combinationally.

The core accepts seven instructions. Three are register-to-register arithmetic: add, subtract and signed set-less-than. Two move data: a word load and a word store, both addressed as base register plus a signed 16-bit offset. Two are conditional branches: branch-if-equal and branch-if-not-equal. Any other opcode, or any register-format funct outside the three supported ones, is executed as a no-operation. A synchronous active-high reset returns the program counter to zero.

Top module: `sc_core32`

## Requirements
- R1: While `rst` is high, `dmem_we` is 0. On the edge after `rst` was high, `imem_addr` becomes 0.
- R2: Any instruction that does not take a branch advances `imem_addr` by 4 on the next edge.
- R3: Register-format add (opcode 000000, funct 100000, rs in bits 25:21, rt in 20:16, rd in 15:11) writes rs+rt modulo 2^32 into rd. The shift field in bits 10:6 has no effect.
- R4: Register-format subtract (funct 100010) writes rs-rt modulo 2^32 into rd.
- R5: Register-format set-less-than (funct 101010) writes 1 into rd when rs is less than rt as signed two's complement values, and writes 0 otherwise.
- R6: Load (opcode 100011) drives `dmem_addr` = rs + sign-extended imm[15:0], keeps `dmem_we` low, and writes `dmem_rdata` into rt.
- R7: Store (opcode 101011) drives `dmem_addr` = rs + sign-extended imm, `dmem_wdata` = rt and `dmem_we` = 1 in its cycle. It writes no register.
- R8: Branch-if-equal (opcode 000100) sets the next `imem_addr` to PC+4+(sign-extended imm << 2) when rs equals rt, and to PC+4 otherwise. Negative offsets are included.
- R9: Branch-if-not-equal (opcode 000101) takes the same target as R8 when rs differs from rt, and goes to PC+4 otherwise.
- R10: Register 0 always reads as zero. Writes that name register 0 are discarded.
- R11: An unsupported opcode, or a register-format funct other than those in R3 to R5, writes no register, keeps `dmem_we` at 0 and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | XLEN | Instruction fetch address (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | XLEN | Data memory byte address |
| dmem_wdata | output | XLEN | Store data |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | XLEN | Load data at `dmem_addr` |

## Verification
The bench acts as both memories, so it controls every fetched word and every load return. It sweeps all ordered pairs drawn from a set of corner operands: zero, one, minus one, the largest and smallest signed values, and a mixed pattern. For each pair it runs add, subtract, set-less-than and both branches. The extreme pairs separate signed from unsigned comparison and expose wrap-around errors. The equal pairs, which are the diagonal of the sweep, separate branch-if-equal from branch-if-not-equal. A negative branch offset exposes a missing sign extension or a missing shift. Targeted patterns then cover load and store offsets, writes to register 0, and no-operation words that must leave registers and memory untouched.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_SLT = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;     // result goes to the register file
    logic    dst_rd;     // destination field: 1 = rd, 0 = rt
    logic    use_imm;    // ALU B operand is the extended immediate
    logic    mem_to_reg; // write-back value comes from data memory
    logic    mem_we;     // store
    logic    br_eq;      // branch when operands are equal
    logic    br_ne;      // branch when operands differ
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    ctl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_REG: begin
        ctl.dst_rd = 1'b1;
        case (funct)
          FN_ADD: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_ADD; end
          FN_SUB: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_SUB; end
          FN_SLT: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_SLT; end
          default: ctl.reg_we = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctl.reg_we     = 1'b1;
        ctl.use_imm    = 1'b1;
        ctl.mem_to_reg = 1'b1;
      end
      OP_STORE: begin
        ctl.use_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctl.br_eq  = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      OP_BNE: begin
        ctl.br_ne  = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] diff;
  logic         lt_signed;

  assign diff      = a - b;
  assign lt_signed = $signed(a) < $signed(b);

  always_comb begin
    case (op)
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
      default: y = a + b;
    endcase
  end

  assign zero = (diff == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  localparam int NREG = 1 << AW;

  logic [W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) mem[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : mem[ra1];
  assign rd2 = (ra2 == '0) ? '0 : mem[ra2];
endmodule

// File: rtl/sc_core32.sv
module sc_core32
  import sc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0]   pc_q, pc_inc, br_tgt, sext;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd, rf_waddr;
  logic [XLEN-1:0]   rs_val, rt_val, alu_b, alu_y, rf_wdata;
  logic              alu_zero, take_br, rf_we;
  logic [4:0]        unused_shamt;
  ctrl_t             ctl;

  assign f_rs         = imem_rdata[25:21];
  assign f_rt         = imem_rdata[20:16];
  assign f_rd         = imem_rdata[15:11];
  assign unused_shamt = imem_rdata[10:6];
  assign sext         = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};

  sc_decode u_dec (
    .opcode (imem_rdata[31:26]),
    .funct  (imem_rdata[5:0]),
    .ctl    (ctl)
  );

  assign rf_we    = ctl.reg_we & ~rst;
  assign rf_waddr = ctl.dst_rd ? f_rd : f_rt;
  assign rf_wdata = ctl.mem_to_reg ? dmem_rdata : alu_y;

  sc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra1   (f_rs),
    .ra2   (f_rt),
    .rd1   (rs_val),
    .rd2   (rt_val)
  );

  assign alu_b = ctl.use_imm ? sext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .op   (ctl.alu_op),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.mem_we & ~rst;

  assign take_br = (ctl.br_eq & alu_zero) | (ctl.br_ne & ~alu_zero);
  assign pc_inc  = pc_q + STEP;
  assign br_tgt  = pc_inc + (sext << 2);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= take_br ? br_tgt : pc_inc;
  end

  assign imem_addr = pc_q;

  // R1: program counter is zero on the edge after reset
  p_reset_pc_r1: assert property (@(posedge clk) rst |=> imem_addr == '0);

  // R2: sequential fetch when no branch is taken
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !take_br |=> imem_addr == $past(imem_addr) + STEP);

  // R8: taken branch lands on PC+4 plus scaled offset
  p_br_target_r8: assert property (@(posedge clk) disable iff (rst)
    take_br |=> imem_addr == $past(imem_addr) + STEP + ($past(sext) << 2));

  // R7: a store never writes the register file
  p_store_no_wb_r7: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !rf_we);

  // R10: register 0 reads as zero from the register file
  p_zero_reg_r10: assert property (@(posedge clk) disable iff (rst)
    (f_rs == '0) |-> (rs_val == '0));

  // R6: a written register reads back its value on the next cycle
  p_wb_readback_r6: assert property (@(posedge clk) disable iff (rst)
    (rf_we && rf_waddr != '0) |=>
      (f_rs != $past(rf_waddr)) || (rs_val == $past(rf_wdata)));

  // R5: set-less-than yields only 0 or 1
  p_slt_range_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl.alu_op == ALU_SLT) |-> (alu_y[XLEN-1:1] == '0));
endmodule

// File: tb/sim_sc_core32.sv
module sim_sc_core32;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  int          n_run  = 0;
  int          n_fail = 0;
  logic [31:0] exp_pc;
  string       pc_tag;
  logic [31:0] vals [6];

  always #2 clk = ~clk;

  sc_core32 u0 (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  function automatic logic [31:0] rtype(int s, int t, int d, int sh, logic [5:0] fn);
    return {6'b000000, 5'(s), 5'(t), 5'(d), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] itype(logic [5:0] op, int s, int t, logic [15:0] imm);
    return {op, 5'(s), 5'(t), imm};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Check the fetch address, present one instruction, let it settle.
  task automatic issue(logic [31:0] ins, logic [31:0] rdv, int adv, string ntag);
    @(negedge clk);
    chk(pc_tag, imem_addr, exp_pc);
    imem_rdata = ins;
    dmem_rdata = rdv;
    exp_pc     = exp_pc + 32'(adv);
    pc_tag     = ntag;
    #1;
  endtask

  task automatic load(int r, logic [31:0] v);
    issue(itype(6'b100011, 0, r, 16'h0000), v, 4, "R2");
    chk("R6", dmem_we, 0);
  endtask

  task automatic peek(int r, logic [31:0] e, string tag);
    issue(itype(6'b101011, 0, r, 16'h0000), 32'h0, 4, "R2");
    chk("R7", dmem_we, 1);
    chk(tag, dmem_wdata, e);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h1234_5678;
    imem_rdata = 32'h0;
    dmem_rdata = 32'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", imem_addr, 32'h0);
    chk("R1", dmem_we, 0);
    rst = 1'b0;
    // word 0 is unsupported: one no-op runs before the first issue (R11)
    exp_pc = 32'h4;
    pc_tag = "R11";

    // Operand sweep: arithmetic, compare and both branches (R3 R4 R5 R8 R9)
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        logic [31:0] a, b;
        a = vals[i];
        b = vals[j];
        load(1, a);
        load(2, b);
        issue(rtype(1, 2, 3, (i * 6 + j) % 32, 6'b100000), 0, 4, "R2");
        issue(rtype(1, 2, 4, 0, 6'b100010), 0, 4, "R2");
        issue(rtype(1, 2, 5, 0, 6'b101010), 0, 4, "R2");
        peek(3, a + b, "R3");
        peek(4, a - b, "R4");
        peek(5, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0, "R5");
        issue(itype(6'b000100, 1, 2, 16'd3), 0, (a == b) ? 16 : 4, "R8");
        issue(itype(6'b000101, 1, 2, 16'hFFFB), 0, (a != b) ? -16 : 4, "R9");
      end
    end

    // R6: load with negative offset, data lands in rt
    load(6, 32'h0000_0100);
    issue(itype(6'b100011, 6, 9, 16'hFFF8), 32'hCAFE_F00D, 4, "R2");
    chk("R6", dmem_addr, 32'h0000_00F8);
    chk("R6", dmem_we, 0);
    peek(9, 32'hCAFE_F00D, "R6");

    // R7: store with positive offset
    issue(itype(6'b101011, 6, 9, 16'd12), 0, 4, "R2");
    chk("R7", dmem_addr, 32'h0000_010C);
    chk("R7", dmem_we, 1);
    chk("R7", dmem_wdata, 32'hCAFE_F00D);
    peek(9, 32'hCAFE_F00D, "R7");

    // R10: register 0 ignores writes
    load(0, 32'h0000_0055);
    issue(rtype(0, 0, 7, 0, 6'b100000), 0, 4, "R2");
    peek(7, 32'h0, "R10");
    peek(0, 32'h0, "R10");
    issue(rtype(9, 9, 0, 0, 6'b100000), 0, 4, "R2");
    peek(0, 32'h0, "R10");

    // R11: unsupported funct and opcode leave state alone
    load(8, 32'd77);
    issue(rtype(9, 9, 8, 0, 6'b100100), 0, 4, "R11");
    chk("R11", dmem_we, 0);
    issue(itype(6'b001000, 9, 8, 16'd5), 0, 4, "R11");
    chk("R11", dmem_we, 0);
    peek(8, 32'd77, "R11");

    @(negedge clk);
    chk(pc_tag, imem_addr, exp_pc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule